// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of the reverse (peripheral-to-host) direction of an ECP-mode parallel port. When a read is requested and the port is still set for forward transfers, it first turns the bus around. It releases its own data drivers, lowers the auto-feed line, waits a setup interval and then lowers the init line. After that it waits for the peripheral to drop the paper-error line. Once the bus is reversed, it handshakes each byte that the peripheral strobes onto the data bus.

Bytes marked as data by a high Busy line go out on a valid/ready byte stream. Bytes marked as commands are decoded in one of two ways. A channel address is dropped and reported with a one-cycle pulse. A run-length count makes the next data byte play back that many extra times, with no bus cycle for the repeats. The requested byte count limits every transfer. A run that is cut short by the count continues at the start of the next transfer. An idle peripheral ends the transfer quietly. A peripheral that stalls in the middle of a handshake ends it with a timeout flag.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, auto_feed_n, init_n, strobe_n and select_in_n are all 1, data_drive_en is 1, and byte_valid and done are 0.
- R2: A start pulse while the port is forward sets data_drive_en to 0 and auto_feed_n to 0 on the next edge. init_n stays 1 for exactly SETUP_TICKS cycles after that, then goes to 0 and stays there.
- R3: After init_n falls during a turnaround, if paper_err stays 1 for RESP_TICKS cycles, the transfer ends with done, done_timeout = 1 and done_count = 0.
- R4: A start pulse while the port is already reversed performs no turnaround. init_n remains 0 throughout.
- R5: When ack_n is low and busy is 1, the byte on data_in is a data byte and is presented on byte_data with byte_valid.
- R6: After a byte is taken in, auto_feed_n goes to 1 until ack_n returns high, then goes back to 0. If ack_n stays low for RESP_TICKS cycles, the transfer ends with done_timeout = 1 and done_count equal to the bytes delivered so far.
- R7: If ack_n does not go low within IDLE_TICKS cycles while the block waits for a byte, the transfer ends with done, done_timeout = 0, and done_count equal to the bytes delivered so far.
- R8: When ack_n is low and busy is 0 with data_in[7] = 1, the byte is a channel address. chan_hit pulses for one cycle with chan_id = data_in[6:0]. No byte is delivered and the run-length state is unchanged.
- R9: When ack_n is low and busy is 0 with data_in[7] = 0, the byte is a run-length command N = data_in[6:0]. The next data byte is delivered once and then N more times, with no bus handshake (auto_feed_n stays 0) during the repeats.
- R10: Repeats are limited by the remaining requested count. Unplayed repeats are delivered first in the next transfer, before any bus cycle.
- R11: While byte_valid is 1 and byte_ready is 0, byte_valid stays 1, byte_data stays stable, and auto_feed_n stays 0.
- R12: A start with req_count = 0 ends at once with done, done_count = 0 and done_timeout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a receive transfer (pulse) |
| req_count | input | CNT_W | Number of bytes requested |
| data_in | input | 8 | Parallel data bus from the peripheral |
| ack_n | input | 1 | Peripheral strobe, active low |
| busy | input | 1 | 1 = data byte, 0 = command byte |
| paper_err | input | 1 | Peripheral acknowledge of bus reversal, low when done |
| data_drive_en | output | 1 | Host data bus driver enable (0 when reversed) |
| auto_feed_n | output | 1 | Host handshake line |
| init_n | output | 1 | Reverse request line |
| strobe_n | output | 1 | Host strobe, held high |
| select_in_n | output | 1 | Select-in line, held high |
| byte_data | output | 8 | Delivered byte |
| byte_valid | output | 1 | Delivered byte valid |
| byte_ready | input | 1 | Sink accepts byte |
| chan_hit | output | 1 | Channel address command seen (pulse) |
| chan_id | output | 7 | Channel number with chan_hit |
| done | output | 1 | Transfer finished (pulse) |
| done_count | output | CNT_W | Bytes delivered in the transfer |
| done_timeout | output | 1 | Transfer ended by a handshake timeout |

## Verification
The two functions that can coincide are the exhaustion of the requested count and a run of repeats that is still playing. They meet when a run-length command asks for more repeats than the transfer has room for. The bench provokes this with a run of four and a request of three bytes. It judges the result by the transfer ending at exactly three bytes. It then checks that a second transfer delivers the two held-over repeats before the new bus bytes.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_TURN,
    S_REV,
    S_LOOP,
    S_WAIT,
    S_EMIT,
    S_REL,
    S_REPLAY,
    S_DONE
  } rx_state_t;
endpackage

// File: rtl/ecp_rev_timer.sv
module ecp_rev_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = (cnt_q == limit - TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ecp_rev_runlen.sv
module ecp_rev_runlen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_cmd,
  input  logic [6:0] load_len,
  input  logic       cap_data,
  input  logic [7:0] cap_byte,
  input  logic       dec,
  output logic [6:0] run_len,
  output logic       armed,
  output logic [7:0] rep_byte
);
  logic [6:0] len_d;
  logic       arm_d;
  logic [7:0] rep_d;
  logic       rep_en;

  assign rep_en = cap_data && armed;

  always_comb begin
    len_d = run_len;
    arm_d = armed;
    if (load_cmd) begin
      len_d = load_len;
      arm_d = 1'b1;
    end else if (rep_en) begin
      arm_d = 1'b0;
    end else if (dec) begin
      len_d = run_len - 7'd1;
    end
    rep_d = rep_en ? cap_byte : rep_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      armed    <= 1'b0;
      rep_byte <= '0;
    end else begin
      run_len  <= len_d;
      armed    <= arm_d;
      rep_byte <= rep_d;
    end
  end
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
  parameter int CNT_W       = 16,
  parameter int SETUP_TICKS = 125,
  parameter int RESP_TICKS  = 750,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_count,
  input  logic [7:0]       data_in,
  input  logic             ack_n,
  input  logic             busy,
  input  logic             paper_err,
  output logic             data_drive_en,
  output logic             auto_feed_n,
  output logic             init_n,
  output logic             strobe_n,
  output logic             select_in_n,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic             chan_hit,
  output logic [6:0]       chan_id,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic             done_timeout
);
  import ecp_rev_pkg::*;

  localparam int MAX_A = (SETUP_TICKS > RESP_TICKS) ? SETUP_TICKS : RESP_TICKS;
  localparam int MAX_T = (MAX_A > IDLE_TICKS) ? MAX_A : IDLE_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);

  rx_state_t        st_q, st_d;
  logic             rev_q, rev_d;
  logic [CNT_W-1:0] rem_q, rem_d, cnt_q, cnt_d;
  logic             err_q, err_d;
  logic [7:0]       byte_q, byte_d;
  logic             ack_s, busy_s, perr_s;
  logic [7:0]       data_s;
  logic [TW-1:0]    limit;
  logic             t_exp, fire;
  logic             load_cmd, cap_data, rep_dec;
  logic [6:0]       run_len;
  logic             armed;
  logic [7:0]       rep_byte;
  logic             seen;

  // Input capture stage: all peripheral lines sampled together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s  <= 1'b1;
      busy_s <= 1'b0;
      perr_s <= 1'b1;
      data_s <= '0;
    end else begin
      ack_s  <= ack_n;
      busy_s <= busy;
      perr_s <= paper_err;
      data_s <= data_in;
    end
  end

  assign seen     = (st_q == S_WAIT) && !ack_s;
  assign load_cmd = seen && !busy_s && !data_s[7];
  assign chan_hit = seen && !busy_s && data_s[7];
  assign chan_id  = data_s[6:0];
  assign cap_data = seen && busy_s;
  assign rep_dec  = (st_q == S_REPLAY) && byte_ready;

  always_comb begin
    case (st_q)
      S_TURN:  limit = TW'(SETUP_TICKS);
      S_WAIT:  limit = TW'(IDLE_TICKS);
      default: limit = TW'(RESP_TICKS);
    endcase
  end

  ecp_rev_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .limit(limit), .expire(t_exp)
  );

  ecp_rev_runlen u_run (
    .clk(clk), .rst_n(rst_n),
    .load_cmd(load_cmd), .load_len(data_s[6:0]),
    .cap_data(cap_data), .cap_byte(data_s),
    .dec(rep_dec),
    .run_len(run_len), .armed(armed), .rep_byte(rep_byte)
  );

  assign byte_valid = (st_q == S_EMIT) || (st_q == S_REPLAY);
  assign byte_data  = (st_q == S_REPLAY) ? rep_byte : byte_q;
  assign fire       = byte_valid && byte_ready;

  always_comb begin
    st_d   = st_q;
    rev_d  = rev_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    byte_d = byte_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        rem_d = req_count;
        cnt_d = '0;
        err_d = 1'b0;
        if (req_count == '0) st_d = S_DONE;
        else if (!rev_q) begin
          st_d  = S_TURN;
          rev_d = 1'b1;
        end else st_d = S_LOOP;
      end
      S_TURN: if (t_exp) st_d = S_REV;
      S_REV: begin
        if (!perr_s) st_d = S_LOOP;
        else if (t_exp) begin
          st_d  = S_DONE;
          err_d = 1'b1;
        end
      end
      S_LOOP: begin
        if (rem_q == '0) st_d = S_DONE;
        else if (run_len != '0 && !armed) st_d = S_REPLAY;
        else st_d = S_WAIT;
      end
      S_WAIT: begin
        if (!ack_s) begin
          st_d   = busy_s ? S_EMIT : S_REL;
          byte_d = data_s;
        end else if (t_exp) st_d = S_DONE;
      end
      S_EMIT: if (byte_ready) st_d = S_REL;
      S_REL: begin
        if (ack_s) st_d = S_LOOP;
        else if (t_exp) begin
          st_d  = S_DONE;
          err_d = 1'b1;
        end
      end
      S_REPLAY: if (byte_ready && (run_len == 7'd1 || rem_q == CNT_W'(1)))
        st_d = S_LOOP;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (fire) begin
      rem_d = rem_q - CNT_W'(1);
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rev_q  <= 1'b0;
      rem_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      rev_q  <= rev_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      byte_q <= byte_d;
    end
  end

  assign data_drive_en = !rev_q;
  assign auto_feed_n   = !rev_q || (st_q == S_REL);
  assign init_n        = !rev_q || (st_q == S_TURN);
  assign strobe_n      = 1'b1;
  assign select_in_n   = 1'b1;
  assign done          = (st_q == S_DONE);
  assign done_count    = cnt_q;
  assign done_timeout  = err_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_drive_en,
  input logic       auto_feed_n,
  input logic       init_n,
  input logic [7:0] byte_data,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic       chan_hit,
  input logic       done
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> !data_drive_en);

  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_drive_en) |-> init_n && !auto_feed_n);

  p_quiet_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !auto_feed_n);

  p_chan_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_hit |-> !byte_valid);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_valid && !chan_hit);
endmodule

bind ecp_rev_rx ecp_rev_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_drive_en(data_drive_en),
  .auto_feed_n(auto_feed_n), .init_n(init_n), .byte_data(byte_data),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .chan_hit(chan_hit),
  .done(done)
);

// File: tb/ecp_rev_rx_bench.sv
module ecp_rev_rx_bench;
  localparam int CW = 8;
  localparam int SU = 4;
  localparam int RS = 16;
  localparam int ID = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] req = '0;
  logic [7:0] din = '0;
  logic ack_n = 1'b1, busy = 1'b0, perr = 1'b1, rdy = 1'b1;
  logic drv, afd, initn, strb, seln, bval, chit, dn, dto;
  logic [7:0] bdat;
  logic [6:0] cid;
  logic [CW-1:0] dcnt;

  int checks = 0, errors = 0;
  logic [7:0] got [0:63];
  int ngot = 0, ndone = 0, nchan = 0, nrise = 0, nturn = 0;
  int last_cnt = 0, last_to = 0, last_chan = 0;
  logic afd_prev = 1'b1;

  always #4 clk = ~clk;

  ecp_rev_rx #(.CNT_W(CW), .SETUP_TICKS(SU), .RESP_TICKS(RS), .IDLE_TICKS(ID)) u_ecp_rev_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req), .data_in(din),
    .ack_n(ack_n), .busy(busy), .paper_err(perr), .data_drive_en(drv),
    .auto_feed_n(afd), .init_n(initn), .strobe_n(strb), .select_in_n(seln),
    .byte_data(bdat), .byte_valid(bval), .byte_ready(rdy), .chan_hit(chit),
    .chan_id(cid), .done(dn), .done_count(dcnt), .done_timeout(dto)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bval && rdy) begin
        if (ngot < 64) got[ngot] = bdat;
        ngot++;
      end
      if (dn) begin ndone++; last_cnt = dcnt; last_to = dto; end
      if (chit) begin nchan++; last_chan = cid; end
      if (afd && !afd_prev) nrise++;
      if (!drv && initn) nturn++;
      afd_prev = afd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ack_n = 1'b1; perr = 1'b1; busy = 1'b0; rdy = 1'b1; start = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic go(input int n);
    @(posedge clk); #2;
    req = CW'(n); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_afd(input logic v);
    for (int i = 0; i < 500 && afd !== v; i++) cyc(1);
  endtask

  task automatic put(input logic [7:0] b, input logic is_data);
    @(posedge clk); #2;
    din = b; busy = is_data; ack_n = 1'b0;
    wait_afd(1'b1);
    ack_n = 1'b1;
    wait_afd(1'b0);
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 2000 && ndone == base; i++) cyc(1);
  endtask

  task automatic t_reset();
    chk(afd && initn && strb && seln, "R1 pins", {afd, initn, strb, seln}, 15);
    chk(drv == 1'b1, "R1 drive", drv, 1);
    chk(!bval && !dn, "R1 valid/done", {bval, dn}, 0);
  endtask

  task automatic t_perr_timeout();
    int d0 = ndone, tb = nturn;
    go(2);
    wait_done(d0);
    chk(nturn - tb == SU, "R2 setup cycles", nturn - tb, SU);
    chk(last_to == 1, "R3 timeout flag", last_to, 1);
    chk(last_cnt == 0, "R3 count", last_cnt, 0);
    chk(drv == 0 && initn == 0, "R2 bus reversed", {drv, initn}, 0);
  endtask

  task automatic t_turn_ok();
    int d0 = ndone, g0 = ngot;
    go(2);
    for (int i = 0; i < 100 && initn; i++) cyc(1);
    cyc(2);
    perr = 1'b0;
    put(8'h11, 1'b1);
    put(8'h22, 1'b1);
    wait_done(d0);
    chk(ngot - g0 == 2, "R5 bytes", ngot - g0, 2);
    chk(got[g0] == 8'h11 && got[g0+1] == 8'h22, "R5 data", got[g0+1], 8'h22);
    chk(last_cnt == 2 && last_to == 0, "R6 clean end", last_cnt, 2);
    chk(afd == 0, "R6 afd low after", afd, 0);
  endtask

  task automatic t_no_turn();
    int d0 = ndone, tb = nturn, g0 = ngot;
    go(1);
    put(8'h5A, 1'b1);
    wait_done(d0);
    chk(nturn == tb, "R4 no turnaround", nturn - tb, 0);
    chk(got[g0] == 8'h5A && last_cnt == 1, "R4 byte", got[g0], 8'h5A);
  endtask

  task automatic t_chan();
    int d0 = ndone, g0 = ngot, c0 = nchan;
    go(2);
    put(8'h85, 1'b0);
    put(8'h40, 1'b1);
    put(8'h41, 1'b1);
    wait_done(d0);
    chk(nchan - c0 == 1 && last_chan == 5, "R8 chan pulse", last_chan, 5);
    chk(ngot - g0 == 2, "R8 no extra bytes", ngot - g0, 2);
    chk(got[g0] == 8'h40 && got[g0+1] == 8'h41, "R8 data order", got[g0+1], 8'h41);
  endtask

  task automatic t_run();
    int d0 = ndone, g0 = ngot, r0;
    bit ok = 1;
    go(5);
    put(8'h03, 1'b0);
    r0 = nrise;
    put(8'h7E, 1'b1);
    put(8'h01, 1'b1);
    wait_done(d0);
    chk(ngot - g0 == 5, "R9 total", ngot - g0, 5);
    for (int i = 0; i < 4; i++) if (got[g0+i] != 8'h7E) ok = 0;
    chk(ok, "R9 repeats", got[g0+3], 8'h7E);
    chk(got[g0+4] == 8'h01, "R9 after run", got[g0+4], 1);
    chk(nrise - r0 == 2, "R9 no handshake on repeats", nrise - r0, 2);
  endtask

  task automatic t_carry();
    int d0 = ndone, g0 = ngot;
    go(3);
    put(8'h04, 1'b0);
    put(8'hA5, 1'b1);
    wait_done(d0);
    chk(last_cnt == 3 && ngot - g0 == 3, "R10 limited", last_cnt, 3);
    chk(got[g0+2] == 8'hA5, "R10 repeat value", got[g0+2], 8'hA5);
    d0 = ndone; g0 = ngot;
    go(4);
    cyc(6);
    chk(ngot - g0 == 2, "R10 leftover before bus", ngot - g0, 2);
    put(8'h3C, 1'b1);
    put(8'h3D, 1'b1);
    wait_done(d0);
    chk(got[g0] == 8'hA5 && got[g0+1] == 8'hA5, "R10 leftover data", got[g0+1], 8'hA5);
    chk(got[g0+2] == 8'h3C && got[g0+3] == 8'h3D, "R10 new data", got[g0+3], 8'h3D);
  endtask

  task automatic t_bp();
    int d0 = ndone, g0 = ngot;
    rdy = 1'b0;
    go(1);
    @(posedge clk); #2;
    din = 8'hC3; busy = 1'b1; ack_n = 1'b0;
    cyc(8);
    chk(bval == 1 && bdat == 8'hC3, "R11 held", bdat, 8'hC3);
    chk(afd == 0, "R11 no handshake", afd, 0);
    rdy = 1'b1;
    wait_afd(1'b1);
    ack_n = 1'b1;
    wait_done(d0);
    chk(ngot - g0 == 1 && got[g0] == 8'hC3, "R11 delivered once", ngot - g0, 1);
  endtask

  task automatic t_idle();
    int d0 = ndone;
    go(2);
    put(8'h77, 1'b1);
    wait_done(d0);
    chk(last_cnt == 1 && last_to == 0, "R7 quiet end", last_to, 0);
  endtask

  task automatic t_rel_timeout();
    int d0 = ndone;
    go(2);
    @(posedge clk); #2;
    din = 8'h99; busy = 1'b1; ack_n = 1'b0;
    wait_done(d0);
    chk(last_to == 1 && last_cnt == 1, "R6 stuck ack", last_cnt, 1);
    ack_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_zero();
    int d0 = ndone, r0 = nrise;
    go(0);
    wait_done(d0);
    chk(last_cnt == 0 && last_to == 0 && nrise == r0, "R12 zero request", last_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_perr_timeout();
    do_reset();
    t_turn_ok();
    t_no_turn();
    t_chan();
    t_run();
    t_carry();
    t_bp();
    t_idle();
    t_rel_timeout();
    t_zero();
    cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule